// File: doc/BRIEF.md
# Multi-Channel DMA Trigger Scheduler

This block sits between the event sources of a four-channel DMA controller and its transfer engine. Each cycle it gathers start requests: an immediate-start pulse raised by a control write, vertical-blank and horizontal-blank pulses, and a sound-FIFO request that carries a FIFO address. Each request becomes a channel index in a first-in first-out queue. One event can produce several entries. A blank pulse queues every enabled channel whose timing field matches the pulse. A sound request queues the sound-capable channels whose destination address equals the supplied address.

The scheduler issues queued indices one at a time as a grant, strictly in arrival order. It holds each grant until the engine reports that the burst is complete. When a burst ends on a channel whose interrupt enable is set, the scheduler pulses that channel's line in a fixed interrupt vector, at position channel + 8. A sticky flag records any request that was lost because the queue was full.

Top module: `dma_trig_sched`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `grant_valid`, `work_pending`, `overflow` and `irq_lines` are all 0.
- R2: An `imm_start` pulse queues `imm_chan`, whatever the state of that channel's enable bit.
- R3: A `vblank` pulse queues, lowest index first, every channel whose enable bit is 1 and whose 2-bit timing field (`ch_timing[2n+1:2n]`) equals 1.
- R4: An `hblank` pulse queues, lowest index first, every enabled channel whose timing field equals 2.
- R5: A `snd_req` pulse queues channel 1 and then channel 2, each only if it is enabled, has timing field 3 and has `ch_dst[32n+31:32n]` equal to `snd_addr`. Channels 0 and 3 never respond.
- R6: Entries produced in the same cycle are queued in this order: immediate start, vertical blank, horizontal blank, sound.
- R7: Grants leave the queue oldest first. After any edge at which `grant_valid` is low and the queue is non-empty, `grant_valid` is 1 and `grant_chan` holds the oldest entry.
- R8: `grant_valid` and `grant_chan` hold until an edge where `xfer_done` is 1. At that edge `grant_valid` clears. `xfer_done` has no effect while no grant is held.
- R9: `work_pending` is 1 exactly when the queue holds at least one entry.
- R10: The queue holds 8 entries. A slot freed by a grant at an edge is usable by pushes at that same edge. Entries beyond the free space are dropped, latest in queue order first. Any drop sets `overflow`, which stays set until reset.
- R11: If `xfer_done` is 1 while a grant on channel n is held and `ch_irq_en[n]` is 1, then `irq_lines[n+8]` is 1 for the next cycle only. At all other times `irq_lines` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_enable | input | 4 | Per-channel enable bit |
| ch_timing | input | 8 | Per-channel start timing: 0 immediate, 1 vertical blank, 2 horizontal blank, 3 sound |
| ch_dst | input | 128 | Per-channel destination address register |
| ch_irq_en | input | 4 | Per-channel completion interrupt enable |
| imm_start | input | 1 | Immediate-start pulse from a control write |
| imm_chan | input | 2 | Channel that the immediate start refers to |
| vblank | input | 1 | Vertical-blank pulse |
| hblank | input | 1 | Horizontal-blank pulse |
| snd_req | input | 1 | Sound-FIFO refill request |
| snd_addr | input | 32 | FIFO address that goes with the sound request |
| xfer_done | input | 1 | Engine has finished the granted burst |
| grant_valid | output | 1 | A grant is held |
| grant_chan | output | 2 | Channel of the held grant |
| work_pending | output | 1 | Queue is non-empty |
| overflow | output | 1 | Sticky flag for a dropped request |
| irq_lines | output | 16 | Interrupt vector, channel n on bit n+8 |

## Verification
The bench aims at cycles where several events coincide. A design that ranked by source or by channel number instead of the stated order would grant the same channels in a different sequence. It fills the queue with a burst of blank pulses while a grant is held, and then again while a slot frees up in the same cycle. An off-by-one in free space would either drop one entry too many or overwrite an entry still waiting. Sound requests are sent with a matching address, a non-matching address, and to channels that are not sound-capable. A design that ignored the address compare or the channel restriction would queue spurious channels. The bench also pulses done while no grant is held. A design that acted on that done would release nothing visible but raise an interrupt on the wrong line.

// File: rtl/dma_sched_pkg.sv
// Shared constants for the DMA trigger scheduler.
// Assumes a 2-bit timing field per channel.
package dma_sched_pkg;
    localparam int TIM_W = 2;
    localparam logic [TIM_W-1:0] TIM_IMMEDIATE = 2'd0;
    localparam logic [TIM_W-1:0] TIM_VBLANK    = 2'd1;
    localparam logic [TIM_W-1:0] TIM_HBLANK    = 2'd2;
    localparam logic [TIM_W-1:0] TIM_SOUND     = 2'd3;
endpackage

// File: rtl/dma_req_collect.sv
// Turns this cycle's events into an ordered vector of request slots.
// Slot order is the queue order: immediate, vblank ch0..N-1,
// hblank ch0..N-1, sound ch SND_LO..SND_HI.
// Assumes: event inputs are single-cycle pulses; purely combinational.
module dma_req_collect
    import dma_sched_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int AW     = 32,
    parameter int CW     = 2,
    parameter int SND_LO = 1,
    parameter int SND_HI = 2,
    parameter int NSLOT  = 1 + 2*NCH + (SND_HI - SND_LO + 1)
) (
    input  logic [NCH-1:0]       ch_enable,
    input  logic [TIM_W*NCH-1:0] ch_timing,
    input  logic [AW*NCH-1:0]    ch_dst,
    input  logic                 imm_start,
    input  logic [CW-1:0]        imm_chan,
    input  logic                 vblank,
    input  logic                 hblank,
    input  logic                 snd_req,
    input  logic [AW-1:0]        snd_addr,
    output logic [NSLOT-1:0]     slot_vld,
    output logic [NSLOT*CW-1:0]  slot_ch
);
    localparam int NSND    = SND_HI - SND_LO + 1;
    localparam int VB_BASE = 1;
    localparam int HB_BASE = 1 + NCH;
    localparam int SN_BASE = 1 + 2*NCH;

    // Immediate start takes the first slot.
    assign slot_vld[0]    = imm_start;
    assign slot_ch[CW-1:0] = imm_chan;

    // One vblank slot and one hblank slot per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_blank
        logic [TIM_W-1:0] tim;
        assign tim = ch_timing[TIM_W*g +: TIM_W];
        assign slot_vld[VB_BASE+g] = vblank & ch_enable[g] & (tim == TIM_VBLANK);
        assign slot_ch[(VB_BASE+g)*CW +: CW] = CW'(g);
        assign slot_vld[HB_BASE+g] = hblank & ch_enable[g] & (tim == TIM_HBLANK);
        assign slot_ch[(HB_BASE+g)*CW +: CW] = CW'(g);
    end

    // Sound slots only for sound-capable channels, matched on address.
    for (genvar s = 0; s < NSND; s++) begin : g_snd
        localparam int CH = SND_LO + s;
        assign slot_vld[SN_BASE+s] = snd_req & ch_enable[CH]
                                   & (ch_timing[TIM_W*CH +: TIM_W] == TIM_SOUND)
                                   & (ch_dst[AW*CH +: AW] == snd_addr);
        assign slot_ch[(SN_BASE+s)*CW +: CW] = CW'(CH);
    end
endmodule

// File: rtl/dma_id_fifo.sv
// Circular queue of channel indices with many pushes and one pop per cycle.
// Valid slots are packed by rank. Those beyond the free space are dropped.
// A pop in the same cycle frees one slot for the pushes.
// Assumes: DEPTH is a power of two, 2 or more.
module dma_id_fifo #(
    parameter int DEPTH = 8,
    parameter int CW    = 2,
    parameter int NSLOT = 11,
    localparam int PW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSLOT-1:0]    slot_vld,
    input  logic [NSLOT*CW-1:0] slot_ch,
    input  logic                pop_req,
    output logic [CW-1:0]       head,
    output logic                not_empty,
    output logic                drop
);
    logic [CW-1:0]   mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [CNTW-1:0] cnt;
    logic            pop_ok;
    int              rank [NSLOT];
    int              total, space, n_acc;

    // Rank the valid slots and work out how many fit.
    always_comb begin
        pop_ok = pop_req & (cnt != '0);
        space  = DEPTH - int'(cnt) + (pop_ok ? 1 : 0);
        total  = 0;
        for (int i = 0; i < NSLOT; i++) begin
            rank[i] = total;
            if (slot_vld[i]) total = total + 1;
        end
        n_acc = (total < space) ? total : space;
    end

    assign drop      = total > space;
    assign not_empty = cnt != '0;
    assign head      = mem[rd_ptr];

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(n_acc);
            rd_ptr <= rd_ptr + {{(PW-1){1'b0}}, pop_ok};
            cnt    <= cnt + CNTW'(n_acc) - {{(CNTW-1){1'b0}}, pop_ok};
        end
    end

    // Storage write of each accepted slot at its packed position.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NSLOT; i++) begin
            if (slot_vld[i] && rank[i] < space)
                mem[wr_ptr + PW'(rank[i])] <= slot_ch[i*CW +: CW];
        end
    end
endmodule

// File: rtl/dma_grant_ctrl.sv
// Holds one grant at a time and raises completion interrupts.
// Pops the queue whenever no grant is held. Releases the grant on done.
// Assumes: xfer_done is ignored while no grant is held.
module dma_grant_ctrl #(
    parameter int NCH      = 4,
    parameter int CW       = 2,
    parameter int NIRQ     = 16,
    parameter int IRQ_BASE = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            q_not_empty,
    input  logic [CW-1:0]   q_head,
    input  logic            xfer_done,
    input  logic [NCH-1:0]  ch_irq_en,
    output logic            pop,
    output logic            grant_valid,
    output logic [CW-1:0]   grant_chan,
    output logic [NIRQ-1:0] irq_lines
);
    logic            finish;
    logic [NIRQ-1:0] irq_nxt;

    assign pop    = ~grant_valid & q_not_empty;
    assign finish = grant_valid & xfer_done;

    // Map each channel's completion onto its fixed interrupt line.
    for (genvar k = 0; k < NIRQ; k++) begin : g_irq
        if (k >= IRQ_BASE && k < IRQ_BASE + NCH) begin : g_map
            assign irq_nxt[k] = finish & (grant_chan == CW'(k - IRQ_BASE))
                              & ch_irq_en[k - IRQ_BASE];
        end else begin : g_zero
            assign irq_nxt[k] = 1'b0;
        end
    end

    // Grant state and interrupt pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_chan  <= '0;
            irq_lines   <= '0;
        end else begin
            irq_lines <= irq_nxt;
            if (pop) begin
                grant_valid <= 1'b1;
                grant_chan  <= q_head;
            end else if (finish) begin
                grant_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dma_trig_sched.sv
// Top level of the DMA trigger scheduler: request collection, arrival-order
// queue, single outstanding grant, interrupt mapping and sticky overflow.
// Assumes: synchronous active-low reset; events are one-cycle pulses.
module dma_trig_sched
    import dma_sched_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int AW       = 32,
    parameter int DEPTH    = 8,
    parameter int NIRQ     = 16,
    parameter int IRQ_BASE = 8,
    parameter int SND_LO   = 1,
    parameter int SND_HI   = 2,
    localparam int CW      = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       ch_enable,
    input  logic [TIM_W*NCH-1:0] ch_timing,
    input  logic [AW*NCH-1:0]    ch_dst,
    input  logic [NCH-1:0]       ch_irq_en,
    input  logic                 imm_start,
    input  logic [CW-1:0]        imm_chan,
    input  logic                 vblank,
    input  logic                 hblank,
    input  logic                 snd_req,
    input  logic [AW-1:0]        snd_addr,
    input  logic                 xfer_done,
    output logic                 grant_valid,
    output logic [CW-1:0]        grant_chan,
    output logic                 work_pending,
    output logic                 overflow,
    output logic [NIRQ-1:0]      irq_lines
);
    localparam int NSLOT = 1 + 2*NCH + (SND_HI - SND_LO + 1);

    logic [NSLOT-1:0]    slot_vld;
    logic [NSLOT*CW-1:0] slot_ch;
    logic [CW-1:0]       q_head;
    logic                q_drop;
    logic                q_pop;

    dma_req_collect #(
        .NCH(NCH), .AW(AW), .CW(CW), .SND_LO(SND_LO), .SND_HI(SND_HI), .NSLOT(NSLOT)
    ) u_collect (
        .ch_enable(ch_enable), .ch_timing(ch_timing), .ch_dst(ch_dst),
        .imm_start(imm_start), .imm_chan(imm_chan), .vblank(vblank),
        .hblank(hblank), .snd_req(snd_req), .snd_addr(snd_addr),
        .slot_vld(slot_vld), .slot_ch(slot_ch)
    );

    dma_id_fifo #(
        .DEPTH(DEPTH), .CW(CW), .NSLOT(NSLOT)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_ch(slot_ch),
        .pop_req(q_pop), .head(q_head), .not_empty(work_pending), .drop(q_drop)
    );

    dma_grant_ctrl #(
        .NCH(NCH), .CW(CW), .NIRQ(NIRQ), .IRQ_BASE(IRQ_BASE)
    ) u_grant (
        .clk(clk), .rst_n(rst_n), .q_not_empty(work_pending), .q_head(q_head),
        .xfer_done(xfer_done), .ch_irq_en(ch_irq_en), .pop(q_pop),
        .grant_valid(grant_valid), .grant_chan(grant_chan), .irq_lines(irq_lines)
    );

    // Sticky record of any dropped request.
    always_ff @(posedge clk) begin
        if (!rst_n)      overflow <= 1'b0;
        else if (q_drop) overflow <= 1'b1;
    end
endmodule

// File: rtl/dma_trig_sched_chk.sv
// Port-level properties of the DMA trigger scheduler, bound to every instance.
module dma_trig_sched_chk #(
    parameter int CW   = 2,
    parameter int NIRQ = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            xfer_done,
    input logic            grant_valid,
    input logic [CW-1:0]   grant_chan,
    input logic            work_pending,
    input logic            overflow,
    input logic [NIRQ-1:0] irq_lines
);
    // R8
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !xfer_done |=> grant_valid && $stable(grant_chan));
    // R8
    grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && xfer_done |=> !grant_valid);
    // R7
    grant_needs_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> $past(work_pending));
    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R11
    irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_lines));
    // R11
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lines != '0) |-> $past(grant_valid && xfer_done));
endmodule

bind dma_trig_sched dma_trig_sched_chk #(.CW(CW), .NIRQ(NIRQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .grant_valid(grant_valid),
    .grant_chan(grant_chan), .work_pending(work_pending), .overflow(overflow),
    .irq_lines(irq_lines)
);

// File: tb/dma_trig_sched_test.sv
module dma_trig_sched_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   ch_enable = '0;
    logic [7:0]   ch_timing = '0;
    logic [127:0] ch_dst = '0;
    logic [3:0]   ch_irq_en = '0;
    logic         imm_start = 1'b0;
    logic [1:0]   imm_chan = '0;
    logic         vblank = 1'b0, hblank = 1'b0, snd_req = 1'b0;
    logic [31:0]  snd_addr = '0;
    logic         xfer_done = 1'b0;
    logic         grant_valid;
    logic [1:0]   grant_chan;
    logic         work_pending, overflow;
    logic [15:0]  irq_lines;

    localparam logic [31:0] FIFO_A = 32'h0400_00A0;
    localparam logic [31:0] FIFO_B = 32'h0400_00A4;

    int checks = 0, errors = 0;
    string phase = "R1";

    // Bench reference state
    int          mq [0:63];
    int          mcnt;
    bit          mgv, movf;
    int          mgch;
    logic [15:0] mirq;

    dma_trig_sched uut (
        .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .ch_timing(ch_timing),
        .ch_dst(ch_dst), .ch_irq_en(ch_irq_en), .imm_start(imm_start),
        .imm_chan(imm_chan), .vblank(vblank), .hblank(hblank), .snd_req(snd_req),
        .snd_addr(snd_addr), .xfer_done(xfer_done), .grant_valid(grant_valid),
        .grant_chan(grant_chan), .work_pending(work_pending), .overflow(overflow),
        .irq_lines(irq_lines)
    );

    always #5 clk = ~clk;

    function automatic int tim_of(int c);
        return int'(ch_timing[2*c +: 2]);
    endfunction

    function automatic void model_reset();
        mcnt = 0; mgv = 0; movf = 0; mgch = 0; mirq = '0;
    endfunction

    // One edge of the expected behaviour, from the requirements
    function automatic void model_step();
        int push [0:15];
        int np = 0;
        int free, head;
        bit pop;
        if (imm_start) begin push[np] = int'(imm_chan); np++; end            // R2
        if (vblank) for (int c = 0; c < 4; c++)
            if (ch_enable[c] && tim_of(c) == 1) begin push[np] = c; np++; end // R3
        if (hblank) for (int c = 0; c < 4; c++)
            if (ch_enable[c] && tim_of(c) == 2) begin push[np] = c; np++; end // R4
        if (snd_req) for (int c = 1; c <= 2; c++)
            if (ch_enable[c] && tim_of(c) == 3 && ch_dst[32*c +: 32] == snd_addr) begin
                push[np] = c; np++;                                          // R5
            end
        pop  = !mgv && mcnt > 0;
        head = mq[0];
        free = 8 - mcnt + (pop ? 1 : 0);
        mirq = (mgv && xfer_done && ch_irq_en[mgch]) ? (16'd1 << (mgch + 8)) : 16'd0;
        if (pop) begin
            for (int k = 0; k < mcnt - 1; k++) mq[k] = mq[k+1];
            mcnt--;
            mgv = 1; mgch = head;
        end else if (mgv && xfer_done) begin
            mgv = 0;
        end
        for (int k = 0; k < np; k++) begin
            if (k < free) begin mq[mcnt] = push[k]; mcnt++; end
            else movf = 1;
        end
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (phase %s) %s actual=%0d expected=%0d",
                     req, phase, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(grant_valid == mgv, "R8", "grant_valid", int'(grant_valid), int'(mgv));
        if (mgv) chk(int'(grant_chan) == mgch, "R7", "grant_chan", int'(grant_chan), mgch);
        chk(work_pending == (mcnt > 0), "R9", "work_pending", int'(work_pending), int'(mcnt > 0));
        chk(overflow == movf, "R10", "overflow", int'(overflow), int'(movf));
        chk(irq_lines == mirq, "R11", "irq_lines", int'(irq_lines), int'(mirq));
    endtask

    // Advance one clock, update expectations, sample 1 ns later, clear pulses
    task automatic cyc();
        @(posedge clk);
        if (!rst_n) model_reset(); else model_step();
        #1;
        compare();
        imm_start = 0; vblank = 0; hblank = 0; snd_req = 0; xfer_done = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) cyc();
        rst_n = 1;
        cyc();
    endtask

    // Completes every grant until the queue and the engine are idle
    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin
            xfer_done = mgv;
            cyc();
        end
    endtask

    task automatic set_tim(input int c, input logic [1:0] v);
        ch_timing[2*c +: 2] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        phase = "R1";
        do_reset();

        // R2: immediate start on a disabled channel still queues it
        phase = "R2";
        ch_enable = 4'b0000; imm_start = 1; imm_chan = 2'd3;
        cyc();
        drain(6);

        // R3/R6: immediate ch2 with vblank on ch0,1,3 -> 2,0,1,3
        phase = "R3_R6";
        ch_enable = 4'b1111; ch_irq_en = 4'b1010;
        set_tim(0, 1); set_tim(1, 1); set_tim(2, 0); set_tim(3, 1);
        imm_start = 1; imm_chan = 2'd2; vblank = 1;
        cyc();
        repeat (3) cyc();
        drain(12);

        // R4/R6: vblank ch1, hblank ch0,3 in one cycle -> 1,0,3
        phase = "R4_R6";
        set_tim(0, 2); set_tim(1, 1); set_tim(2, 3); set_tim(3, 2);
        vblank = 1; hblank = 1;
        cyc();
        drain(10);

        // R5: address match and channel restriction for sound requests
        phase = "R5";
        set_tim(0, 3); set_tim(1, 3); set_tim(2, 3); set_tim(3, 3);
        ch_dst[0 +: 32] = FIFO_A; ch_dst[32 +: 32] = FIFO_A;
        ch_dst[64 +: 32] = FIFO_B; ch_dst[96 +: 32] = FIFO_A;
        snd_req = 1; snd_addr = FIFO_A; cyc(); drain(4);
        snd_req = 1; snd_addr = FIFO_B; cyc(); drain(4);
        snd_req = 1; snd_addr = 32'h0400_0000; cyc(); drain(4);
        ch_dst[64 +: 32] = FIFO_A;
        snd_req = 1; snd_addr = FIFO_A; cyc(); drain(6);

        // R8: done with no grant held is ignored
        phase = "R8";
        xfer_done = 1; cyc(); xfer_done = 1; cyc();

        // R10: fill with vblank bursts while no done arrives
        phase = "R10";
        set_tim(0, 1); set_tim(1, 1); set_tim(2, 1); set_tim(3, 1);
        vblank = 1; cyc();
        vblank = 1; cyc();
        vblank = 1; cyc();
        repeat (3) cyc();
        drain(20);
        phase = "R1";
        do_reset();

        // R11 and overall ordering under random stimulus
        for (int i = 0; i < 4000; i++) begin
            phase = "R7_R11_rand";
            if (i == 2000) begin phase = "R1"; do_reset(); end
            if (($urandom % 16) == 0) begin
                ch_enable = 4'($urandom);
                ch_timing = 8'($urandom);
                ch_irq_en = 4'($urandom);
                for (int c = 0; c < 4; c++)
                    ch_dst[32*c +: 32] = (($urandom % 3) == 0) ? FIFO_B :
                                         (($urandom % 2) == 0) ? FIFO_A : 32'h0300_0000;
            end
            imm_start = (($urandom % 6) == 0);
            imm_chan  = 2'($urandom);
            vblank    = (($urandom % 20) == 0);
            hblank    = (($urandom % 8) == 0);
            snd_req   = (($urandom % 7) == 0);
            snd_addr  = (($urandom % 2) == 0) ? FIFO_A : FIFO_B;
            xfer_done = mgv ? (($urandom % 3) == 0) : (($urandom % 8) == 0);
            cyc();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule